// File: doc/BRIEF.md
# Palette Host Access Controller

This block is the processor-facing side of a colour lookup unit. A host reaches it over an 8-bit bidirectional data bus with active-low read and write strobes and a 3-bit register select. Through it the host loads an address pointer and a pixel read mask. It also streams red, green and blue bytes into or out of a 256-entry, 24-bit palette store and a small overlay colour file that the block holds itself. The palette store sits outside the block: the controller drives its write port and its read port, and it receives read data one clock after each read request.

Palette writes are assembled from three byte cycles and committed as one word. Palette reads are prefetched into a holding register as soon as a read address is loaded, and again after each blue byte. This lets a host stream consecutive entries with no extra address writes. All strobes are sampled on the block clock. The select is taken when a strobe falls, and an access takes effect when its strobe rises.

Top module: `clut_host_if`

## Requirements
- R1: After reset the address pointer is 0, the pointer is in write mode for the palette, the next byte is red, the read mask is 8'hFF, every overlay entry is zero, and neither palette port is active.
- R2: A write with select 3'b000 (palette) or 3'b100 (overlay) loads the pointer from the bus, enters write mode for that space and restarts at red. Select 3'b011 (palette) or 3'b111 (overlay) does the same but enters read mode.
- R3: In write mode, three data writes (select 3'b001 for the palette) are taken as red, green, blue. After blue, one palette write of {red[23:16], green[15:8], blue[7:0]} is issued at the pointer, and the pointer then steps by one.
- R4: A red or a green data write alone causes no palette write.
- R5: Loading a read address issues one palette read at that address. The entry is taken into the holding register one clock after the request, and the pointer then steps to the following address.
- R6: In read mode, data reads return the held red, green and blue bytes in that order. After the blue read the entry at the current pointer is fetched and the pointer steps again.
- R7: Overlay data (select 3'b101) follows the same sequences against overlay entries 1 to 15, selected by pointer bits 3:0. A write to index 0 is discarded, and index 0 reads as zero.
- R8: Select 3'b010 writes and reads the 8-bit read mask. The mask changes only on such a write.
- R9: Reads with select 3'b000, 3'b011, 3'b100 or 3'b111 return the current pointer.
- R10: With the six-bit option set, a written byte keeps only bits 5:0, stored as {b[5:0], 2'b00}. A read returns {2'b00, c[7:2]} of the stored component c.
- R11: The pointer wraps from 255 to 0 after a palette commit and after a fetch.
- R12: The block drives the data bus only while the read strobe is low.
- R13: These accesses change nothing and leave the sequence in place: data writes in read mode, data accesses whose select names the other space, and any access with select 3'b110. The matching reads return 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_sel | input | 3 | Register select |
| host_d | inout | 8 | Host data bus |
| six_bit_mode | input | 1 | Six-bit component option |
| pal_we | output | 1 | Palette store write enable |
| pal_waddr | output | 8 | Palette store write address |
| pal_wdata | output | 24 | Palette store write word |
| pal_re | output | 1 | Palette store read request |
| pal_raddr | output | 8 | Palette store read address |
| pal_rdata | input | 24 | Palette store read word, valid one clock after pal_re |
| read_mask | output | 8 | Pixel read mask |
| ovl_table | output | 360 | Overlay entries 1..15, entry k at bits [k*24-1 -: 24] |

## Verification
The properties assume the host never lowers both strobes together. They also assume that a strobe stays high long enough for a pending fetch to finish before the next access, which means at least three clocks after a rising edge. The six-bit option must change only while no access is in flight. The stimulus holds each strobe low for two clocks and then leaves five idle clocks. It changes the select and the option only while both strobes are high, so every fetch, commit and pointer step settles before the next falling edge.

// File: rtl/clut_host_pkg.sv
package clut_host_pkg;

    typedef enum logic [1:0] {
        COMP_RED = 2'd0,
        COMP_GRN = 2'd1,
        COMP_BLU = 2'd2
    } comp_e;

    typedef enum logic [2:0] {
        SEL_PAL_WADDR = 3'b000,
        SEL_PAL_DATA  = 3'b001,
        SEL_MASK      = 3'b010,
        SEL_PAL_RADDR = 3'b011,
        SEL_OVL_WADDR = 3'b100,
        SEL_OVL_DATA  = 3'b101,
        SEL_SPARE     = 3'b110,
        SEL_OVL_RADDR = 3'b111
    } sel_e;

endpackage

// File: rtl/clut_strobe_edge.sv
module clut_strobe_edge #(
    parameter int unsigned BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_n,
    input  logic             wr_n,
    input  logic [2:0]       sel_in,
    input  logic [BUS_W-1:0] bus_in,
    output logic             rd_done,
    output logic             wr_done,
    output logic [2:0]       sel_eff,
    output logic [BUS_W-1:0] wr_byte
);

    typedef struct packed {
        logic             rd_prev;
        logic             wr_prev;
        logic [2:0]       sel_cap;
        logic [BUS_W-1:0] byte_cap;
    } edge_st_t;

    edge_st_t st_d, st_q;
    logic     any_fall;

    always_comb begin
        st_d     = st_q;
        any_fall = (!rd_n && st_q.rd_prev) || (!wr_n && st_q.wr_prev);
        st_d.rd_prev = rd_n;
        st_d.wr_prev = wr_n;
        if (any_fall) begin
            st_d.sel_cap = sel_in;
        end
        if (!wr_n) begin
            st_d.byte_cap = bus_in;
        end
        rd_done = rd_n && !st_q.rd_prev;
        wr_done = wr_n && !st_q.wr_prev;
        sel_eff = any_fall ? sel_in : st_q.sel_cap;
        wr_byte = st_q.byte_cap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{rd_prev: 1'b1, wr_prev: 1'b1, sel_cap: 3'b000, byte_cap: '0};
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/clut_ovl_file.sv
module clut_ovl_file #(
    parameter int unsigned ENTRIES = 15,
    parameter int unsigned WORD_W  = 24,
    parameter int unsigned IDX_W   = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [IDX_W-1:0]          widx,
    input  logic [WORD_W-1:0]         wword,
    input  logic [IDX_W-1:0]          ridx,
    output logic [WORD_W-1:0]         rword,
    output logic [ENTRIES*WORD_W-1:0] table_o
);

    logic [WORD_W-1:0] ent_d [ENTRIES];
    logic [WORD_W-1:0] ent_q [ENTRIES];

    always_comb begin
        rword = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            ent_d[e] = (we && (widx == IDX_W'(e + 1))) ? wword : ent_q[e];
            if (ridx == IDX_W'(e + 1)) begin
                rword = ent_q[e];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) begin
                ent_q[e] <= '0;
            end
        end else begin
            for (int e = 0; e < ENTRIES; e++) begin
                ent_q[e] <= ent_d[e];
            end
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_flat
        assign table_o[g*WORD_W +: WORD_W] = ent_q[g];
    end

endmodule

// File: rtl/clut_seq.sv
module clut_seq
    import clut_host_pkg::*;
#(
    parameter int unsigned COMP_W    = 8,
    parameter int unsigned OVL_IDX_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_done_i,
    input  logic                  rd_done_i,
    input  logic [2:0]            sel_i,
    input  logic [COMP_W-1:0]     wr_byte_i,
    input  logic                  six_bit_i,
    input  logic [3*COMP_W-1:0]   pal_rdata_i,
    input  logic [3*COMP_W-1:0]   ovl_rword_i,
    output logic                  pal_we_o,
    output logic [COMP_W-1:0]     pal_waddr_o,
    output logic [3*COMP_W-1:0]   pal_wdata_o,
    output logic                  pal_re_o,
    output logic [COMP_W-1:0]     pal_raddr_o,
    output logic                  ovl_we_o,
    output logic [OVL_IDX_W-1:0]  ovl_widx_o,
    output logic [3*COMP_W-1:0]   ovl_wword_o,
    output logic [OVL_IDX_W-1:0]  ovl_ridx_o,
    output logic [COMP_W-1:0]     rd_byte_o,
    output logic [COMP_W-1:0]     mask_o,
    output logic [COMP_W-1:0]     addr_o
);

    localparam int unsigned ADDR_W = COMP_W;
    localparam int unsigned WORD_W = 3 * COMP_W;
    localparam int unsigned PAD_W  = 2;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        comp_e             comp;
        logic              rd_mode;
        logic              ovl_space;
        logic [COMP_W-1:0] red_part;
        logic [COMP_W-1:0] grn_part;
        logic [WORD_W-1:0] hold;
        logic [COMP_W-1:0] mask;
        logic              we;
        logic [ADDR_W-1:0] waddr;
        logic [WORD_W-1:0] wdata;
        logic              re;
        logic [ADDR_W-1:0] raddr;
        logic              fetch;
        logic              cap;
        logic              cap_ovl;
    } seq_st_t;

    seq_st_t           st_d, st_q;
    sel_e              sel;
    logic              data_match;
    logic              is_ovl_sel;
    logic [COMP_W-1:0] lane_in;
    logic [COMP_W-1:0] comp_byte;

    always_comb begin
        sel        = sel_e'(sel_i);
        is_ovl_sel = (sel == SEL_OVL_DATA);
        data_match = ((sel == SEL_PAL_DATA) || (sel == SEL_OVL_DATA)) &&
                     (is_ovl_sel == st_q.ovl_space);
        lane_in    = six_bit_i ? {wr_byte_i[COMP_W-PAD_W-1:0], {PAD_W{1'b0}}} : wr_byte_i;

        st_d       = st_q;
        st_d.we    = 1'b0;
        st_d.re    = 1'b0;
        st_d.fetch = 1'b0;
        st_d.cap   = st_q.fetch;

        ovl_we_o    = 1'b0;
        ovl_widx_o  = st_q.addr[OVL_IDX_W-1:0];
        ovl_wword_o = {st_q.red_part, st_q.grn_part, lane_in};
        ovl_ridx_o  = st_q.addr[OVL_IDX_W-1:0];

        // completion of a prefetch: entry into holding register, pointer steps
        if (st_q.cap) begin
            st_d.hold = st_q.cap_ovl ? ovl_rword_i : pal_rdata_i;
            st_d.addr = st_q.addr + ADDR_W'(1);
        end

        if (wr_done_i) begin
            unique case (sel)
                SEL_PAL_WADDR, SEL_OVL_WADDR: begin
                    st_d.addr      = wr_byte_i;
                    st_d.rd_mode   = 1'b0;
                    st_d.ovl_space = (sel == SEL_OVL_WADDR);
                    st_d.comp      = COMP_RED;
                end
                SEL_PAL_RADDR, SEL_OVL_RADDR: begin
                    st_d.addr      = wr_byte_i;
                    st_d.rd_mode   = 1'b1;
                    st_d.ovl_space = (sel == SEL_OVL_RADDR);
                    st_d.comp      = COMP_RED;
                    st_d.fetch     = 1'b1;
                    st_d.cap_ovl   = (sel == SEL_OVL_RADDR);
                    st_d.re        = (sel != SEL_OVL_RADDR);
                    st_d.raddr     = wr_byte_i;
                end
                SEL_MASK: begin
                    st_d.mask = wr_byte_i;
                end
                SEL_PAL_DATA, SEL_OVL_DATA: begin
                    if (data_match && !st_q.rd_mode) begin
                        unique case (st_q.comp)
                            COMP_RED: begin
                                st_d.red_part = lane_in;
                                st_d.comp     = COMP_GRN;
                            end
                            COMP_GRN: begin
                                st_d.grn_part = lane_in;
                                st_d.comp     = COMP_BLU;
                            end
                            default: begin
                                if (st_q.ovl_space) begin
                                    ovl_we_o = 1'b1;
                                end else begin
                                    st_d.we    = 1'b1;
                                    st_d.waddr = st_q.addr;
                                    st_d.wdata = {st_q.red_part, st_q.grn_part, lane_in};
                                end
                                st_d.addr = st_q.addr + ADDR_W'(1);
                                st_d.comp = COMP_RED;
                            end
                        endcase
                    end
                end
                SEL_SPARE: begin
                end
            endcase
        end

        if (rd_done_i && data_match && st_q.rd_mode) begin
            unique case (st_q.comp)
                COMP_RED: st_d.comp = COMP_GRN;
                COMP_GRN: st_d.comp = COMP_BLU;
                default: begin
                    st_d.comp    = COMP_RED;
                    st_d.fetch   = 1'b1;
                    st_d.cap_ovl = st_q.ovl_space;
                    st_d.re      = !st_q.ovl_space;
                    st_d.raddr   = st_q.addr;
                end
            endcase
        end
    end

    always_comb begin
        unique case (st_q.comp)
            COMP_RED: comp_byte = st_q.hold[WORD_W-1 -: COMP_W];
            COMP_GRN: comp_byte = st_q.hold[2*COMP_W-1 -: COMP_W];
            default:  comp_byte = st_q.hold[COMP_W-1:0];
        endcase
        unique case (sel)
            SEL_PAL_WADDR, SEL_PAL_RADDR,
            SEL_OVL_WADDR, SEL_OVL_RADDR: rd_byte_o = st_q.addr;
            SEL_MASK:                     rd_byte_o = st_q.mask;
            SEL_PAL_DATA, SEL_OVL_DATA: begin
                if (data_match && st_q.rd_mode) begin
                    rd_byte_o = six_bit_i ? {{PAD_W{1'b0}}, comp_byte[COMP_W-1:PAD_W]} : comp_byte;
                end else begin
                    rd_byte_o = '0;
                end
            end
            default:                      rd_byte_o = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{addr: '0, comp: COMP_RED, rd_mode: 1'b0, ovl_space: 1'b0,
                      red_part: '0, grn_part: '0, hold: '0, mask: '1,
                      we: 1'b0, waddr: '0, wdata: '0, re: 1'b0, raddr: '0,
                      fetch: 1'b0, cap: 1'b0, cap_ovl: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign pal_we_o    = st_q.we;
    assign pal_waddr_o = st_q.waddr;
    assign pal_wdata_o = st_q.wdata;
    assign pal_re_o    = st_q.re;
    assign pal_raddr_o = st_q.raddr;
    assign mask_o      = st_q.mask;
    assign addr_o      = st_q.addr;

endmodule

// File: rtl/clut_host_if.sv
module clut_host_if
    import clut_host_pkg::*;
#(
    parameter int unsigned BUS_W = 8,
    parameter int unsigned OVL_N = 15
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       host_rd_n,
    input  logic                       host_wr_n,
    input  logic [2:0]                 host_sel,
    inout  wire  [BUS_W-1:0]           host_d,
    input  logic                       six_bit_mode,
    output logic                       pal_we,
    output logic [BUS_W-1:0]           pal_waddr,
    output logic [3*BUS_W-1:0]         pal_wdata,
    output logic                       pal_re,
    output logic [BUS_W-1:0]           pal_raddr,
    input  logic [3*BUS_W-1:0]         pal_rdata,
    output logic [BUS_W-1:0]           read_mask,
    output logic [OVL_N*3*BUS_W-1:0]   ovl_table
);

    localparam int unsigned WORD_W    = 3 * BUS_W;
    localparam int unsigned OVL_IDX_W = $clog2(OVL_N + 1);

    logic                 rd_done, wr_done;
    logic [2:0]           sel_eff;
    logic [BUS_W-1:0]     wr_byte;
    logic [BUS_W-1:0]     rd_byte;
    logic [BUS_W-1:0]     cur_addr;
    logic                 ovl_we;
    logic [OVL_IDX_W-1:0] ovl_widx, ovl_ridx;
    logic [WORD_W-1:0]    ovl_wword, ovl_rword;

    clut_strobe_edge #(.BUS_W(BUS_W)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_n    (host_rd_n),
        .wr_n    (host_wr_n),
        .sel_in  (host_sel),
        .bus_in  (host_d),
        .rd_done (rd_done),
        .wr_done (wr_done),
        .sel_eff (sel_eff),
        .wr_byte (wr_byte)
    );

    clut_seq #(.COMP_W(BUS_W), .OVL_IDX_W(OVL_IDX_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_done_i   (wr_done),
        .rd_done_i   (rd_done),
        .sel_i       (sel_eff),
        .wr_byte_i   (wr_byte),
        .six_bit_i   (six_bit_mode),
        .pal_rdata_i (pal_rdata),
        .ovl_rword_i (ovl_rword),
        .pal_we_o    (pal_we),
        .pal_waddr_o (pal_waddr),
        .pal_wdata_o (pal_wdata),
        .pal_re_o    (pal_re),
        .pal_raddr_o (pal_raddr),
        .ovl_we_o    (ovl_we),
        .ovl_widx_o  (ovl_widx),
        .ovl_wword_o (ovl_wword),
        .ovl_ridx_o  (ovl_ridx),
        .rd_byte_o   (rd_byte),
        .mask_o      (read_mask),
        .addr_o      (cur_addr)
    );

    clut_ovl_file #(.ENTRIES(OVL_N), .WORD_W(WORD_W), .IDX_W(OVL_IDX_W)) u_ovl (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (ovl_we),
        .widx    (ovl_widx),
        .wword   (ovl_wword),
        .ridx    (ovl_ridx),
        .rword   (ovl_rword),
        .table_o (ovl_table)
    );

    assign host_d = host_rd_n ? {BUS_W{1'bz}} : rd_byte;

endmodule

// File: rtl/clut_host_if_chk.sv
module clut_host_if_chk #(
    parameter int unsigned ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_rd_n,
    input logic              host_wr_n,
    input logic              pal_we,
    input logic [ADDR_W-1:0] pal_waddr,
    input logic              pal_re,
    input logic [ADDR_W-1:0] pal_raddr,
    input logic [ADDR_W-1:0] cur_addr,
    input logic [ADDR_W-1:0] read_mask
);

    // R1: mask is all ones in the cycle after any reset cycle
    a_r1_mask_reset: assert property (@(posedge clk)
        !rst_n |=> (read_mask == {ADDR_W{1'b1}}));

    // R3: a palette commit follows a rising write strobe
    a_r3_commit_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        pal_we |-> ($past(host_wr_n) && !$past(host_wr_n, 2)));

    // R3 and R11: the pointer has stepped past the committed address, wrapping
    a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        pal_we |-> (cur_addr == pal_waddr + ADDR_W'(1)));

    // R5: two clocks after a read request the pointer is one past it
    a_r5_fetch_step: assert property (@(posedge clk) disable iff (!rst_n)
        pal_re |=> ##1 (cur_addr == $past(pal_raddr, 2) + ADDR_W'(1)));

    // R8: mask holds unless a write strobe has just risen
    a_r8_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr_n && !$past(host_wr_n)) |=> $stable(read_mask));

    // R13: ignored accesses never reach both storage ports together
    a_r13_no_port_clash: assert property (@(posedge clk) disable iff (!rst_n)
        !(pal_we && pal_re));

    // R12: bus direction is defined only when strobes are exclusive
    a_r12_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!host_rd_n && !host_wr_n));

endmodule

bind clut_host_if clut_host_if_chk #(.ADDR_W(BUS_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_rd_n (host_rd_n),
    .host_wr_n (host_wr_n),
    .pal_we    (pal_we),
    .pal_waddr (pal_waddr),
    .pal_re    (pal_re),
    .pal_raddr (pal_raddr),
    .cur_addr  (cur_addr),
    .read_mask (read_mask)
);

// File: tb/clut_host_if_tb.sv
module clut_host_if_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int SAMPLE_OFS = CLK_PERIOD / 5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         host_rd_n = 1'b1;
    logic         host_wr_n = 1'b1;
    logic [2:0]   host_sel = 3'b000;
    logic         six_bit_mode = 1'b0;
    logic [7:0]   tb_d = 8'h00;
    logic         tb_oe = 1'b0;
    wire  [7:0]   host_d;
    logic         pal_we, pal_re;
    logic [7:0]   pal_waddr, pal_raddr, read_mask;
    logic [23:0]  pal_wdata;
    logic [23:0]  pal_rdata = 24'h0;
    logic [359:0] ovl_table;

    assign host_d = tb_oe ? tb_d : 8'bzzzzzzzz;

    clut_host_if dut_i (
        .clk(clk), .rst_n(rst_n), .host_rd_n(host_rd_n), .host_wr_n(host_wr_n),
        .host_sel(host_sel), .host_d(host_d), .six_bit_mode(six_bit_mode),
        .pal_we(pal_we), .pal_waddr(pal_waddr), .pal_wdata(pal_wdata),
        .pal_re(pal_re), .pal_raddr(pal_raddr), .pal_rdata(pal_rdata),
        .read_mask(read_mask), .ovl_table(ovl_table)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // palette storage (environment)
    logic [23:0] ram [256];
    always @(posedge clk) begin
        if (pal_we) ram[pal_waddr] <= pal_wdata;
        if (pal_re) pal_rdata <= ram[pal_raddr];
    end

    // reference model state
    int          n_chk = 0;
    int          n_fail = 0;
    int          n_we = 0;
    bit          done = 0;
    int          m_addr, m_comp, m_rd, m_ovl, m_mask;
    logic [7:0]  m_red, m_grn;
    logic [23:0] m_hold;
    logic [23:0] m_pal [256];
    logic [23:0] m_ovlreg [16];
    logic [31:0] wq [$];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [23:0] m_fetch(input int a);
        if (m_ovl != 0) return ((a % 16) == 0) ? 24'h0 : m_ovlreg[a % 16];
        return m_pal[a];
    endfunction

    task automatic model_write(input int sel, input logic [7:0] b);
        logic [7:0]  lane;
        logic [23:0] word;
        lane = six_bit_mode ? {b[5:0], 2'b00} : b;
        case (sel)
            0, 4: begin m_addr = b; m_rd = 0; m_ovl = (sel == 4); m_comp = 0; end
            3, 7: begin
                m_addr = b; m_rd = 1; m_ovl = (sel == 7); m_comp = 0;
                m_hold = m_fetch(m_addr); m_addr = (m_addr + 1) % 256;
            end
            2: m_mask = b;
            1, 5: begin
                if (((sel == 5) == (m_ovl != 0)) && m_rd == 0) begin
                    if (m_comp == 0) begin m_red = lane; m_comp = 1; end
                    else if (m_comp == 1) begin m_grn = lane; m_comp = 2; end
                    else begin
                        word = {m_red, m_grn, lane};
                        if (m_ovl == 0) begin
                            wq.push_back({m_addr[7:0], word});
                            m_pal[m_addr] = word;
                        end else if ((m_addr % 16) != 0) begin
                            m_ovlreg[m_addr % 16] = word;
                        end
                        m_addr = (m_addr + 1) % 256; m_comp = 0;
                    end
                end
            end
            default: ;
        endcase
    endtask

    task automatic model_read(input int sel, output logic [7:0] v);
        logic [7:0] c;
        v = 8'h00;
        case (sel)
            0, 3, 4, 7: v = m_addr[7:0];
            2: v = m_mask[7:0];
            1, 5: begin
                if (((sel == 5) == (m_ovl != 0)) && m_rd != 0) begin
                    c = (m_comp == 0) ? m_hold[23:16] : (m_comp == 1) ? m_hold[15:8] : m_hold[7:0];
                    v = six_bit_mode ? {2'b00, c[7:2]} : c;
                    if (m_comp == 2) begin
                        m_comp = 0; m_hold = m_fetch(m_addr); m_addr = (m_addr + 1) % 256;
                    end else m_comp++;
                end
            end
            default: ;
        endcase
    endtask

    task automatic host_write(input int sel, input logic [7:0] b);
        @(negedge clk);
        host_sel = sel[2:0]; tb_d = b; tb_oe = 1'b1; host_wr_n = 1'b0;
        repeat (2) @(negedge clk);
        host_wr_n = 1'b1;
        model_write(sel, b);
        @(negedge clk);
        tb_oe = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic host_read(input int sel, input string tag);
        logic [7:0] exp;
        @(negedge clk);
        host_sel = sel[2:0]; host_rd_n = 1'b0;
        @(negedge clk);
        model_read(sel, exp);
        chk(tag, {24'h0, host_d}, {24'h0, exp});
        @(negedge clk);
        host_rd_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    // per-clock comparison against the model
    always @(posedge clk) begin
        #(SAMPLE_OFS);
        if (rst_n && !done) begin
            chk("R8 mask", {24'h0, read_mask}, m_mask);
            for (int k = 1; k < 16; k++)
                chk("R7 overlay entry", ovl_table[(k-1)*24 +: 24], m_ovlreg[k]);
            if (tb_oe) chk("R12 bus released", {24'h0, host_d}, {24'h0, tb_d});
            if (pal_we) begin
                n_we++;
                if (wq.size() == 0) chk("R4 unexpected palette write", 1, 0);
                else begin
                    logic [31:0] e;
                    e = wq.pop_front();
                    chk("R3 commit address", pal_waddr, e[31:24]);
                    chk("R3 commit word", pal_wdata, e[23:0]);
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int we_before;
        for (int i = 0; i < 256; i++) begin ram[i] = 24'h0; m_pal[i] = 24'h0; end
        for (int i = 0; i < 16; i++) m_ovlreg[i] = 24'h0;
        m_addr = 0; m_comp = 0; m_rd = 0; m_ovl = 0; m_mask = 8'hFF;
        m_red = 8'h0; m_grn = 8'h0; m_hold = 24'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 mask", {24'h0, read_mask}, 32'hFF);
        chk("R1 write port idle", {31'h0, pal_we}, 0);
        chk("R1 read port idle", {31'h0, pal_re}, 0);
        chk("R1 overlays zero", {31'h0, |ovl_table}, 0);
        host_read(0, "R1 R9 pointer");
        host_read(1, "R1 R13 data read in write mode");

        // R2 R9 address load
        host_write(0, 8'h10);
        host_read(0, "R9 pointer after load");
        // R3 R4 commit sequence
        we_before = n_we;
        host_write(1, 8'h11);
        host_write(1, 8'h22);
        chk("R4 no write before blue", n_we, we_before);
        host_write(1, 8'h33);
        chk("R3 one write after blue", n_we, we_before + 1);
        host_read(4, "R3 pointer stepped");
        host_write(1, 8'hA1); host_write(1, 8'hB2); host_write(1, 8'hC3);
        // R11 wrap on commit
        host_write(0, 8'hFF);
        host_write(1, 8'h01); host_write(1, 8'h02); host_write(1, 8'h03);
        host_read(0, "R11 pointer wrapped");

        // R5 R6 streaming reads
        host_write(3, 8'h10);
        host_read(3, "R5 pointer after prefetch");
        for (int i = 0; i < 6; i++) host_read(1, "R6 streamed byte");
        host_read(0, "R6 pointer after two entries");
        // R13 ignored accesses
        host_write(1, 8'h77);
        host_write(6, 8'h99);
        host_read(6, "R13 spare select reads zero");
        host_read(5, "R13 other space reads zero");
        host_read(1, "R13 sequence intact");
        // R11 wrap on fetch
        host_write(3, 8'hFF);
        for (int i = 0; i < 6; i++) host_read(1, "R11 stream across wrap");
        host_read(0, "R11 pointer after wrap");

        // R8 mask
        host_write(2, 8'h5A);
        host_read(2, "R8 mask readback");

        // R7 overlay
        host_write(4, 8'h03);
        host_write(5, 8'h44); host_write(5, 8'h55); host_write(5, 8'h66);
        host_write(1, 8'hEE);
        host_write(4, 8'h00);
        host_write(5, 8'h12); host_write(5, 8'h34); host_write(5, 8'h56);
        host_read(4, "R7 pointer after discarded entry");
        host_write(7, 8'h03);
        for (int i = 0; i < 3; i++) host_read(5, "R7 overlay readback");
        host_write(7, 8'h00);
        host_read(5, "R7 index zero reads zero");

        // R10 six-bit option
        @(negedge clk);
        six_bit_mode = 1'b1;
        host_write(0, 8'h40);
        host_write(1, 8'hFF); host_write(1, 8'h01); host_write(1, 8'h2A);
        host_write(3, 8'h40);
        for (int i = 0; i < 3; i++) host_read(1, "R10 six-bit readback");
        six_bit_mode = 1'b0;
        host_write(3, 8'h40);
        host_read(1, "R10 stored left aligned");

        repeat (4) @(negedge clk);
        chk("R3 all commits seen", wq.size(), 0);
        finish_run();
    end

endmodule